// File: doc/BRIEF.md
# Memory-Type Range Register File

This block holds the memory-type range configuration of one processor core: a set of variable base/mask pairs, eleven fixed-range registers that each carry eight type bytes for the first megabyte of memory, a default-type control word, a page-attribute word and a read-only capability word. Software reaches it through a single-request port. Each request names a 12-bit register address and, for writes, carries 64 bits of data. One cycle later the block answers with a response that carries read data, an error bit and a fault bit.

Every write is checked before it is committed. Each register class has its own legality rules: which type codes are allowed and which bits are reserved. A write that breaks them is refused and leaves all stored state untouched. When a base or mask value sets a reserved bit, the block also raises a general-protection fault flag. An accepted write also emits a one-cycle invalidate pulse with the byte span it affects, so that translation caches downstream can drop stale entries. The whole decoded state is presented on flat output buses for a neighbouring type resolver.

Top module: `mrange_regfile`

## Requirements
- R1: Every request is answered exactly one cycle later with `rsp_valid` high for a single cycle. A read or write to an address that decodes to no register returns `rsp_err`=1.
- R2: A read of address 0x0FE returns 0x500 OR NUM_VAR. A write to 0x0FE is refused with `rsp_err`=1.
- R3: The legal memory-type codes are 0, 1, 4, 5 and 6. The fixed-range registers sit at 0x250 (64 KB granule), 0x258–0x259 (16 KB) and 0x268–0x26F (4 KB), giving register numbers 0, 1–2 and 3–10. Data byte k of register r lands in lane 8·r+k of `mr_fixed_types`, where lane j occupies bits 8j+7:8j. A write is refused if any of its eight bytes holds an illegal code.
- R4: The page-attribute register at 0x277 accepts a write only when each of its eight bytes is 0, 1, 4, 5, 6 or 7.
- R5: The default-type register at 0x2FF refuses data with any bit set outside 0xCFF, and data whose bits 7:0 are not a legal memory type. Bit 11 drives `mr_enable`, bit 10 drives `mr_fixed_en` and bits 7:0 drive `mr_def_type`.
- R6: Variable pairs occupy addresses 0x200 through 0x200+2·NUM_VAR−1, with the base at even addresses and the mask at odd ones. Pair p is (addr−0x200)/2 and appears in bits 64p+63:64p of `mr_var_base` and `mr_var_mask`. A base needs a legal type in bits 7:0. If that fails, the write is refused without a fault. A base must also have bits 11:8 and all bits at or above PHYS_W clear. A mask must have bits 10:0 and all bits at or above PHYS_W clear. A write that breaks either reserved-bit rule is refused with `rsp_fault`=1.
- R7: A refused write changes no stored value, and a following read returns the earlier contents.
- R8: An accepted fixed-range write pulses `inv_valid` with the register's byte span. The span starts at segment base + unit·8·granule and ends one register span later, exclusive. The pulse is suppressed when fixed ranges are disabled (bit 10 clear) or when the global enable (bit 11) is clear.
- R9: An accepted default-type write always pulses `inv_valid` with start 0 and end 0xFFFF_FFFF_FFFF_FFFF.
- R10: An accepted variable write, with the global enable set, pulses `inv_valid`. The start is the base with bits 11:0 cleared. The end is ((start & m) | ~m) + 1, where m is the mask with bits 11:0 cleared and all bits at or above PHYS_W set. The pair's other half is taken from storage.
- R11: No invalidate is issued for page-attribute writes, for reads, or for fixed or variable writes while the global enable is clear.
- R12: After reset every stored register is zero, `rsp_valid` and `inv_valid` are low, and all reads of writable registers return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Register address |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_err | output | 1 | Request refused or address undecoded |
| rsp_fault | output | 1 | Reserved-bit violation in a variable register |
| rsp_rdata | output | 64 | Read data (zero on writes and errors) |
| inv_valid | output | 1 | Invalidate pulse |
| inv_start | output | 64 | First byte of the invalidated span |
| inv_end | output | 64 | End of the span (exclusive) |
| mr_enable | output | 1 | Global range enable |
| mr_fixed_en | output | 1 | Fixed-range enable |
| mr_def_type | output | 8 | Default memory type |
| mr_fixed_types | output | 704 | 88 fixed-range type bytes |
| mr_var_base | output | 64·NUM_VAR | Variable base words |
| mr_var_mask | output | 64·NUM_VAR | Variable mask words |
| mr_page_attr | output | 64 | Page-attribute word |

## Verification
The assertions assume a request lasts one cycle, with address and data meaningful only while `req_valid` is high. They also assume stored state changes only through that port, so a refused response can be compared with the state one cycle earlier. The directed bench drives each request for exactly one cycle and leaves an idle cycle between requests, so a response and its invalidate pulse are never overlapped by a later request. The fixed and variable scenarios first set the default-type enables explicitly, so the gating of the invalidate pulse is always known when its span is predicted.

// File: rtl/mrange_pkg.sv
// Package: shared constants, register classes and type-legality helpers for
// the memory-type range register file. Assumes 12-bit register addresses and
// 64-bit register words.
package mrange_pkg;

    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 64;
    localparam int FIX_REGS  = 11;
    localparam int FIX_IW    = $clog2(FIX_REGS);
    localparam int FIX_BYTES = FIX_REGS * 8;

    localparam logic [ADDR_W-1:0] ADR_VAR0     = 12'h200;
    localparam logic [ADDR_W-1:0] ADR_FIX64    = 12'h250;
    localparam logic [ADDR_W-1:0] ADR_FIX16    = 12'h258;
    localparam logic [ADDR_W-1:0] ADR_FIX4     = 12'h268;
    localparam logic [ADDR_W-1:0] ADR_PAGEATTR = 12'h277;
    localparam logic [ADDR_W-1:0] ADR_DEFTYPE  = 12'h2FF;
    localparam logic [ADDR_W-1:0] ADR_CAPS     = 12'h0FE;

    // Segment geometry of the fixed-range registers.
    localparam logic [DATA_W-1:0] SEG0_BASE = 64'h0_0000;
    localparam logic [DATA_W-1:0] SEG1_BASE = 64'h8_0000;
    localparam logic [DATA_W-1:0] SEG2_BASE = 64'hC_0000;
    localparam logic [DATA_W-1:0] SEG0_SPAN = 64'h8_0000;  // 8 x 64 KB
    localparam logic [DATA_W-1:0] SEG1_SPAN = 64'h2_0000;  // 8 x 16 KB
    localparam logic [DATA_W-1:0] SEG2_SPAN = 64'h0_8000;  // 8 x 4 KB
    localparam int SEG1_FIRST = 1;
    localparam int SEG2_FIRST = 3;

    localparam logic [DATA_W-1:0] PAGE_KEEP   = ~64'hFFF;
    localparam logic [DATA_W-1:0] DEFTYPE_OK  = 64'hCFF;
    localparam logic [DATA_W-1:0] BASE_LOWRSV = 64'hF00;
    localparam logic [DATA_W-1:0] MASK_LOWRSV = 64'h7FF;
    localparam logic [DATA_W-1:0] CAP_FLAGS   = 64'h500;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_VAR_BASE,
        CLS_VAR_MASK,
        CLS_FIXED,
        CLS_DEFTYPE,
        CLS_PAGEATTR,
        CLS_CAPS
    } reg_cls_e;

    // True when t is a legal memory-range type code.
    function automatic logic legal_mem_type(input logic [7:0] t);
        return (t == 8'd0) || (t == 8'd1) || (t == 8'd4) || (t == 8'd5) || (t == 8'd6);
    endfunction

    // True when t is a legal page-attribute type code.
    function automatic logic legal_pat_type(input logic [7:0] t);
        return legal_mem_type(t) || (t == 8'd7);
    endfunction

endpackage

// File: rtl/mrange_wr_check.sv
// Module: mrange_wr_check
// Decodes a register address into a class and index, and judges whether the
// request may proceed. Purely combinational. Assumes NUM_VAR pairs fit below
// the fixed-range addresses (2*NUM_VAR <= 0x50).
module mrange_wr_check
    import mrange_pkg::*;
#(
    parameter int NUM_VAR = 8,
    parameter int PHYS_W  = 36,
    localparam int VAR_IW = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              is_write,
    output reg_cls_e          cls,
    output logic [VAR_IW-1:0] var_idx,
    output logic [FIX_IW-1:0] fix_idx,
    output logic              accept,
    output logic              fault
);

    localparam logic [DATA_W-1:0] HI_RSV  = {DATA_W{1'b1}} << PHYS_W;
    localparam logic [ADDR_W-1:0] VAR_TOP = ADR_VAR0 + ADDR_W'(2 * NUM_VAR);

    logic [ADDR_W-1:0] var_off;
    logic              bytes_mem_ok;
    logic              bytes_pat_ok;
    logic              wr_ok;
    logic              wr_fault;

    // Offset of the address within the variable-pair window.
    assign var_off = addr - ADR_VAR0;

    // Address decode into register class, pair index and fixed register number.
    always_comb begin
        cls     = CLS_NONE;
        var_idx = var_off[VAR_IW:1];
        fix_idx = '0;
        if (addr >= ADR_VAR0 && addr < VAR_TOP) begin
            cls = var_off[0] ? CLS_VAR_MASK : CLS_VAR_BASE;
        end else if (addr == ADR_FIX64) begin
            cls = CLS_FIXED;
        end else if (addr == ADR_FIX16 || addr == ADR_FIX16 + 12'd1) begin
            cls     = CLS_FIXED;
            fix_idx = FIX_IW'(SEG1_FIRST) + FIX_IW'(addr[0]);
        end else if (addr >= ADR_FIX4 && addr <= ADR_FIX4 + 12'd7) begin
            cls     = CLS_FIXED;
            fix_idx = FIX_IW'(SEG2_FIRST) + FIX_IW'(addr[2:0]);
        end else if (addr == ADR_PAGEATTR) begin
            cls = CLS_PAGEATTR;
        end else if (addr == ADR_DEFTYPE) begin
            cls = CLS_DEFTYPE;
        end else if (addr == ADR_CAPS) begin
            cls = CLS_CAPS;
        end
    end

    // Legality of all eight data bytes under both type tables.
    always_comb begin
        bytes_mem_ok = 1'b1;
        bytes_pat_ok = 1'b1;
        for (int b = 0; b < 8; b++) begin
            if (!legal_mem_type(data[8*b +: 8])) bytes_mem_ok = 1'b0;
            if (!legal_pat_type(data[8*b +: 8])) bytes_pat_ok = 1'b0;
        end
    end

    // Per-class write rules; faults only for reserved bits in pair registers.
    always_comb begin
        wr_ok    = 1'b0;
        wr_fault = 1'b0;
        unique case (cls)
            CLS_VAR_BASE: begin
                if (legal_mem_type(data[7:0])) begin
                    wr_fault = |(data & (HI_RSV | BASE_LOWRSV));
                    wr_ok    = !wr_fault;
                end
            end
            CLS_VAR_MASK: begin
                wr_fault = |(data & (HI_RSV | MASK_LOWRSV));
                wr_ok    = !wr_fault;
            end
            CLS_FIXED:    wr_ok = bytes_mem_ok;
            CLS_PAGEATTR: wr_ok = bytes_pat_ok;
            CLS_DEFTYPE:  wr_ok = !(|(data & ~DEFTYPE_OK)) && legal_mem_type(data[7:0]);
            default:      wr_ok = 1'b0;
        endcase
    end

    // Reads succeed on any decoded address; writes follow the class rules.
    assign accept = is_write ? wr_ok : (cls != CLS_NONE);
    assign fault  = is_write & wr_fault;

endmodule

// File: rtl/mrange_inv_span.sv
// Module: mrange_inv_span
// Works out whether a committed write must invalidate, and which byte span.
// Combinational. Assumes the caller only acts on its result for accepted writes;
// enable bits are the values stored before the write.
module mrange_inv_span
    import mrange_pkg::*;
#(
    parameter int PHYS_W = 36
) (
    input  reg_cls_e          cls,
    input  logic [FIX_IW-1:0] fix_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cur_base,
    input  logic [DATA_W-1:0] cur_mask,
    input  logic              cur_enable,
    input  logic              cur_fixed_en,
    output logic              hit,
    output logic [DATA_W-1:0] span_start,
    output logic [DATA_W-1:0] span_end
);

    localparam logic [DATA_W-1:0] HI_RSV = {DATA_W{1'b1}} << PHYS_W;

    logic [DATA_W-1:0] base_v;
    logic [DATA_W-1:0] mask_v;
    logic [DATA_W-1:0] var_start;
    logic [DATA_W-1:0] var_eff_mask;
    logic [DATA_W-1:0] fix_start;
    logic [DATA_W-1:0] fix_size;
    logic [DATA_W-1:0] ix;

    // Merge the half being written with the stored other half of the pair.
    assign base_v       = (cls == CLS_VAR_MASK) ? cur_base : wdata;
    assign mask_v       = (cls == CLS_VAR_MASK) ? wdata : cur_mask;
    assign var_start    = base_v & PAGE_KEEP;
    assign var_eff_mask = (mask_v & PAGE_KEEP) | HI_RSV;
    assign ix           = DATA_W'(fix_idx);

    // Byte span of a fixed-range register from its segment and unit.
    always_comb begin
        if (fix_idx < FIX_IW'(SEG1_FIRST)) begin
            fix_size  = SEG0_SPAN;
            fix_start = SEG0_BASE;
        end else if (fix_idx < FIX_IW'(SEG2_FIRST)) begin
            fix_size  = SEG1_SPAN;
            fix_start = SEG1_BASE + (ix - DATA_W'(SEG1_FIRST)) * SEG1_SPAN;
        end else begin
            fix_size  = SEG2_SPAN;
            fix_start = SEG2_BASE + (ix - DATA_W'(SEG2_FIRST)) * SEG2_SPAN;
        end
    end

    // Select span and gating per register class.
    always_comb begin
        hit        = 1'b0;
        span_start = '0;
        span_end   = '0;
        unique case (cls)
            CLS_DEFTYPE: begin
                hit      = 1'b1;
                span_end = {DATA_W{1'b1}};
            end
            CLS_FIXED: begin
                hit        = cur_enable & cur_fixed_en;
                span_start = fix_start;
                span_end   = fix_start + fix_size;
            end
            CLS_VAR_BASE, CLS_VAR_MASK: begin
                hit        = cur_enable;
                span_start = var_start;
                span_end   = ((var_start & var_eff_mask) | ~var_eff_mask) + 64'd1;
            end
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/mrange_regfile.sv
// Module: mrange_regfile (top)
// Memory-type range register file: validated writes, read port with a
// read-only capability word, invalidate-span pulse, flat state outputs.
// Assumes single-cycle requests; the response follows one cycle later.
module mrange_regfile
    import mrange_pkg::*;
#(
    parameter int NUM_VAR = 8,
    parameter int PHYS_W  = 36
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [11:0]               req_addr,
    input  logic [63:0]               req_wdata,
    output logic                      rsp_valid,
    output logic                      rsp_err,
    output logic                      rsp_fault,
    output logic [63:0]               rsp_rdata,
    output logic                      inv_valid,
    output logic [63:0]               inv_start,
    output logic [63:0]               inv_end,
    output logic                      mr_enable,
    output logic                      mr_fixed_en,
    output logic [7:0]                mr_def_type,
    output logic [FIX_REGS*64-1:0]    mr_fixed_types,
    output logic [NUM_VAR*64-1:0]     mr_var_base,
    output logic [NUM_VAR*64-1:0]     mr_var_mask,
    output logic [63:0]               mr_page_attr
);

    localparam int VAR_IW = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1;

    logic [DATA_W-1:0] var_base_q [NUM_VAR];
    logic [DATA_W-1:0] var_mask_q [NUM_VAR];
    logic [DATA_W-1:0] fixed_q    [FIX_REGS];
    logic [DATA_W-1:0] deftype_q;
    logic [DATA_W-1:0] pat_q;

    reg_cls_e          cls;
    logic [VAR_IW-1:0] var_idx;
    logic [FIX_IW-1:0] fix_idx;
    logic              accept;
    logic              fault;
    logic              inv_hit;
    logic [DATA_W-1:0] span_start;
    logic [DATA_W-1:0] span_end;
    logic [DATA_W-1:0] rd_val;
    logic              commit;

    mrange_wr_check #(.NUM_VAR(NUM_VAR), .PHYS_W(PHYS_W)) i_check (
        .addr     (req_addr),
        .data     (req_wdata),
        .is_write (req_write),
        .cls      (cls),
        .var_idx  (var_idx),
        .fix_idx  (fix_idx),
        .accept   (accept),
        .fault    (fault)
    );

    mrange_inv_span #(.PHYS_W(PHYS_W)) i_span (
        .cls          (cls),
        .fix_idx      (fix_idx),
        .wdata        (req_wdata),
        .cur_base     (var_base_q[var_idx]),
        .cur_mask     (var_mask_q[var_idx]),
        .cur_enable   (deftype_q[11]),
        .cur_fixed_en (deftype_q[10]),
        .hit          (inv_hit),
        .span_start   (span_start),
        .span_end     (span_end)
    );

    // A write is committed only when the checker accepts it.
    assign commit = req_valid & req_write & accept;

    // Read multiplexer over all register classes.
    always_comb begin
        unique case (cls)
            CLS_VAR_BASE: rd_val = var_base_q[var_idx];
            CLS_VAR_MASK: rd_val = var_mask_q[var_idx];
            CLS_FIXED:    rd_val = fixed_q[fix_idx];
            CLS_DEFTYPE:  rd_val = deftype_q;
            CLS_PAGEATTR: rd_val = pat_q;
            CLS_CAPS:     rd_val = CAP_FLAGS | DATA_W'(NUM_VAR);
            default:      rd_val = '0;
        endcase
    end

    // Register storage: cleared on reset, updated by committed writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_VAR; i++) begin
                var_base_q[i] <= '0;
                var_mask_q[i] <= '0;
            end
            for (int i = 0; i < FIX_REGS; i++) fixed_q[i] <= '0;
            deftype_q <= '0;
            pat_q     <= '0;
        end else if (commit) begin
            unique case (cls)
                CLS_VAR_BASE: var_base_q[var_idx] <= req_wdata;
                CLS_VAR_MASK: var_mask_q[var_idx] <= req_wdata;
                CLS_FIXED:    fixed_q[fix_idx]    <= req_wdata;
                CLS_DEFTYPE:  deftype_q           <= req_wdata;
                CLS_PAGEATTR: pat_q               <= req_wdata;
                default:      ;
            endcase
        end
    end

    // Response register: one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid & !accept;
            rsp_fault <= req_valid & fault;
            rsp_rdata <= (req_valid && !req_write && accept) ? rd_val : '0;
        end
    end

    // Invalidate pulse register, aligned with the write response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_valid <= 1'b0;
            inv_start <= '0;
            inv_end   <= '0;
        end else begin
            inv_valid <= commit & inv_hit;
            inv_start <= (commit & inv_hit) ? span_start : '0;
            inv_end   <= (commit & inv_hit) ? span_end : '0;
        end
    end

    // Flatten stored state for the neighbouring type resolver.
    generate
        for (genvar p = 0; p < NUM_VAR; p++) begin : g_var_out
            assign mr_var_base[64*p +: 64] = var_base_q[p];
            assign mr_var_mask[64*p +: 64] = var_mask_q[p];
        end
        for (genvar f = 0; f < FIX_REGS; f++) begin : g_fix_out
            assign mr_fixed_types[64*f +: 64] = fixed_q[f];
        end
    endgenerate

    assign mr_enable    = deftype_q[11];
    assign mr_fixed_en  = deftype_q[10];
    assign mr_def_type  = deftype_q[7:0];
    assign mr_page_attr = pat_q;

    // Each request yields exactly one response in the following cycle.
    assert_resp_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_resp_unasked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // A fault is always reported as a refused request.
    assert_fault_is_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_valid && rsp_err));

    // A refused response means no stored word moved.
    assert_reject_keeps_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (mr_fixed_types == $past(mr_fixed_types) &&
                                    mr_var_base == $past(mr_var_base) &&
                                    mr_var_mask == $past(mr_var_mask) &&
                                    deftype_q == $past(deftype_q) &&
                                    pat_q == $past(pat_q)));

    // The stored default type is always a legal code.
    assert_deftype_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        legal_mem_type(mr_def_type));

    // Invalidates come only with successful write responses.
    assert_inval_on_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (rsp_valid && !rsp_err && $past(req_write)));

    // Every invalidated span is non-empty.
    assert_span_ordered_R10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_start < inv_end));

    // Page-attribute writes never invalidate.
    assert_no_inval_pat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> ($past(req_addr) != ADR_PAGEATTR));

endmodule

// File: tb/test_mrange_regfile.sv
// Directed bench for mrange_regfile: one task per scenario, each checking
// its own results at the negative clock edge after the response register.
module test_mrange_regfile;
    localparam int NV = 8;
    localparam int PW = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic rsp_valid, rsp_err, rsp_fault, inv_valid;
    logic [63:0] rsp_rdata, inv_start, inv_end, mr_page_attr;
    logic mr_enable, mr_fixed_en;
    logic [7:0] mr_def_type;
    logic [11*64-1:0] mr_fixed_types;
    logic [NV*64-1:0] mr_var_base, mr_var_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic g_valid, g_err, g_fault, g_inv;
    logic [63:0] g_rdata, g_start, g_end;

    always #2 clk = ~clk;

    mrange_regfile #(.NUM_VAR(NV), .PHYS_W(PW)) i_mrange_regfile (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
        .inv_valid(inv_valid), .inv_start(inv_start), .inv_end(inv_end),
        .mr_enable(mr_enable), .mr_fixed_en(mr_fixed_en), .mr_def_type(mr_def_type),
        .mr_fixed_types(mr_fixed_types), .mr_var_base(mr_var_base),
        .mr_var_mask(mr_var_mask), .mr_page_attr(mr_page_attr)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one request for one cycle and capture the response cycle.
    task automatic access(input logic wr, input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        g_valid = rsp_valid; g_err = rsp_err; g_fault = rsp_fault;
        g_rdata = rsp_rdata; g_inv = inv_valid; g_start = inv_start; g_end = inv_end;
    endtask

    task automatic wr_expect(input string req, input logic [11:0] a, input logic [63:0] d,
                             input logic err, input logic flt, input logic inv,
                             input logic [63:0] s, input logic [63:0] e);
        access(1'b1, a, d);
        check(req, "rsp_valid", 64'(g_valid), 64'd1);
        check(req, "rsp_err", 64'(g_err), 64'(err));
        check(req, "rsp_fault", 64'(g_fault), 64'(flt));
        check(req, "inv_valid", 64'(g_inv), 64'(inv));
        if (inv) begin
            check(req, "inv_start", g_start, s);
            check(req, "inv_end", g_end, e);
        end
    endtask

    task automatic rd_expect(input string req, input logic [11:0] a,
                             input logic err, input logic [63:0] d);
        access(1'b0, a, 64'd0);
        check(req, "read err", 64'(g_err), 64'(err));
        check(req, "read data", g_rdata, d);
        check(req, "read inv_valid", 64'(g_inv), 64'd0);
    endtask

    task automatic t_reset;  // R12
        check("R12", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check("R12", "inv_valid after reset", 64'(inv_valid), 64'd0);
        check("R12", "mr_enable after reset", 64'(mr_enable), 64'd0);
        rd_expect("R12", 12'h2FF, 1'b0, 64'd0);
        rd_expect("R12", 12'h203, 1'b0, 64'd0);
        rd_expect("R12", 12'h277, 1'b0, 64'd0);
        rd_expect("R12", 12'h26A, 1'b0, 64'd0);
    endtask

    task automatic t_caps;  // R2, R1
        rd_expect("R2", 12'h0FE, 1'b0, 64'h500 | 64'(NV));
        @(negedge clk);
        check("R1", "single response cycle", 64'(rsp_valid), 64'd0);
        wr_expect("R2", 12'h0FE, 64'h1, 1'b1, 1'b0, 1'b0, 0, 0);
    endtask

    task automatic t_undecoded;  // R1
        rd_expect("R1", 12'h100, 1'b1, 64'd0);
        rd_expect("R1", 12'h210, 1'b1, 64'd0);
        wr_expect("R1", 12'h100, 64'h0, 1'b1, 1'b0, 1'b0, 0, 0);
    endtask

    task automatic t_deftype;  // R5, R9
        wr_expect("R9", 12'h2FF, 64'hC06, 1'b0, 1'b0, 1'b1, 64'd0, '1);
        check("R5", "mr_enable", 64'(mr_enable), 64'd1);
        check("R5", "mr_fixed_en", 64'(mr_fixed_en), 64'd1);
        check("R5", "mr_def_type", 64'(mr_def_type), 64'd6);
        wr_expect("R5", 12'h2FF, 64'h1006, 1'b1, 1'b0, 1'b0, 0, 0);
        wr_expect("R5", 12'h2FF, 64'hC07, 1'b1, 1'b0, 1'b0, 0, 0);
        wr_expect("R5", 12'h2FF, 64'hC02, 1'b1, 1'b0, 1'b0, 0, 0);
        rd_expect("R5", 12'h2FF, 1'b0, 64'hC06);
    endtask

    task automatic t_fixed;  // R3, R8
        wr_expect("R8", 12'h259, 64'h0605040100060504, 1'b0, 1'b0, 1'b1,
                  64'hA0000, 64'hC0000);
        @(negedge clk);
        check("R8", "inv pulse one cycle", 64'(inv_valid), 64'd0);
        check("R3", "lanes 16..23", mr_fixed_types[16*8 +: 64], 64'h0605040100060504);
        rd_expect("R3", 12'h259, 1'b0, 64'h0605040100060504);
        wr_expect("R3", 12'h268, 64'h0000000000000300, 1'b1, 1'b0, 1'b0, 0, 0);
        rd_expect("R3", 12'h268, 1'b0, 64'd0);
        wr_expect("R8", 12'h26F, 64'h0101010101010101, 1'b0, 1'b0, 1'b1,
                  64'hF8000, 64'h100000);
        check("R3", "lanes 80..87", mr_fixed_types[80*8 +: 64], 64'h0101010101010101);
        wr_expect("R8", 12'h250, 64'h0000000000000005, 1'b0, 1'b0, 1'b1,
                  64'h0, 64'h80000);
        check("R3", "lanes 0..7", mr_fixed_types[63:0], 64'h5);
    endtask

    task automatic t_pat;  // R4, R11
        wr_expect("R4", 12'h277, 64'h0007040600070406, 1'b0, 1'b0, 1'b0, 0, 0);
        check("R4", "mr_page_attr", mr_page_attr, 64'h0007040600070406);
        wr_expect("R4", 12'h277, 64'h0000000000000200, 1'b1, 1'b0, 1'b0, 0, 0);
        check("R11", "pat unchanged after reject", mr_page_attr, 64'h0007040600070406);
    endtask

    task automatic t_variable;  // R6, R10
        wr_expect("R10", 12'h200, 64'h10000006, 1'b0, 1'b0, 1'b1,
                  64'h10000000, 64'h1000000000);
        wr_expect("R10", 12'h201, 64'hFF0000800, 1'b0, 1'b0, 1'b1,
                  64'h10000000, 64'h20000000);
        check("R6", "pair 0 mask out", mr_var_mask[63:0], 64'hFF0000800);
        wr_expect("R6", 12'h200, 64'h10000007, 1'b1, 1'b0, 1'b0, 0, 0);
        wr_expect("R6", 12'h200, 64'h10000106, 1'b1, 1'b1, 1'b0, 0, 0);
        wr_expect("R6", 12'h200, (64'd1 << PW) | 64'h6, 1'b1, 1'b1, 1'b0, 0, 0);
        wr_expect("R6", 12'h20F, 64'h808, 1'b1, 1'b1, 1'b0, 0, 0);
        wr_expect("R6", 12'h20F, 64'hF00000800, 1'b0, 1'b0, 1'b1,
                  64'h0, 64'h100000000);
        check("R6", "pair 7 mask out", mr_var_mask[7*64 +: 64], 64'hF00000800);
        rd_expect("R6", 12'h20F, 1'b0, 64'hF00000800);
    endtask

    task automatic t_reject_state;  // R7
        rd_expect("R7", 12'h200, 1'b0, 64'h10000006);
        rd_expect("R7", 12'h2FF, 1'b0, 64'hC06);
        rd_expect("R7", 12'h268, 1'b0, 64'd0);
    endtask

    task automatic t_disabled;  // R8, R11, R9
        wr_expect("R9", 12'h2FF, 64'h806, 1'b0, 1'b0, 1'b1, 64'd0, '1);
        wr_expect("R8", 12'h250, 64'h0606060606060606, 1'b0, 1'b0, 1'b0, 0, 0);
        rd_expect("R8", 12'h250, 1'b0, 64'h0606060606060606);
        wr_expect("R9", 12'h2FF, 64'h0, 1'b0, 1'b0, 1'b1, 64'd0, '1);
        wr_expect("R11", 12'h202, 64'h20000000, 1'b0, 1'b0, 1'b0, 0, 0);
        wr_expect("R11", 12'h259, 64'h0, 1'b0, 1'b0, 1'b0, 0, 0);
        check("R11", "pair 1 base stored", mr_var_base[64 +: 64], 64'h20000000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_caps();
        t_undecoded();
        t_deftype();
        t_fixed();
        t_pat();
        t_variable();
        t_reject_state();
        t_disabled();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule